// File: doc/BRIEF.md
# Windowed General-Purpose Register File

This block holds the integer registers of a processor core that uses register windows. Software always addresses 32 logical registers with a 5-bit number. The first eight are global: every procedure reaches the same physical entries through them, and register 0 is tied to zero. The other 24 logical registers are translated through a current-window pointer into a larger physical pool. That pool holds eight globals plus sixteen fresh entries per window. With the default of six windows it has 104 entries.

Each window's 24 registers fall into three groups of eight:
- r8..r15 are the outgoing group.
- r16..r23 are private locals.
- r24..r31 are the incoming group.

A save strobe moves the pointer down by one, modulo the window count. A restore strobe moves it up by one. After a save, the caller's outgoing group is the same physical storage as the callee's incoming group, so arguments pass without copying. A per-window invalid mask tells the block which neighbouring windows may not be entered. If a move would enter one, the block raises an overflow or underflow flag in the same cycle and keeps the pointer where it was. Moving windows to and from memory is left to the trap handler that reacts to these flags.

The block has two combinational read ports and one synchronous write port. A write presented in the same cycle as a read of the same register is forwarded to that read port.

Top module: `windowed_regfile`

## Requirements
- R1: After reset the window pointer `cwp_o` equals the `RESET_CWP` parameter (default 0), and both `overflow_o` and `underflow_o` are low.
- R2: Logical register 0 reads as zero on both read ports at all times. A write to it changes no register and is not forwarded.
- R3: Logical registers 1..7 reach the same storage whatever the window pointer holds. A value written in one window reads back unchanged in every other window.
- R4: Logical registers 16..23 are private to each window. Writes made in other windows never change them.
- R5: With the pointer at window w, logical register 8+k (k = 0..7) is the same storage as logical register 24+k with the pointer at window (w-1) mod NWIN.
- R6: A save strobe alone sets the pointer to (w-1) mod NWIN on the next clock. A restore strobe alone sets it to (w+1) mod NWIN, so window NWIN-1 wraps to 0 and 0 wraps to NWIN-1. With no strobe the pointer holds.
- R7: Bit i of `win_invalid` marks window i as invalid. A lone save whose target window (w-1) mod NWIN is invalid drives `overflow_o` high during that cycle and leaves the pointer unchanged. A lone restore whose target (w+1) mod NWIN is invalid does the same with `underflow_o`. The two flags are never high together.
- R8: Save and restore strobed in the same cycle cancel. The pointer holds and neither flag rises.
- R9: A write in the same cycle as a save or restore is translated with the window that was current before the move.
- R10: When a write to register n (n ≠ 0) is presented, a read port addressing n in the same cycle returns the write data.
- R11: The two read ports are independent. Each returns the register its own address selects in the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_addr | input | 5 | Logical register number for read port 0 |
| rd0_data | output | DW | Read port 0 data, combinational |
| rd1_addr | input | 5 | Logical register number for read port 1 |
| rd1_data | output | DW | Read port 1 data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move the window down by one |
| restore_req | input | 1 | Move the window up by one |
| win_invalid | input | NWIN | One bit per window; 1 marks the window as not enterable |
| cwp_o | output | CW | Current window pointer |
| overflow_o | output | 1 | A save was refused this cycle |
| underflow_o | output | 1 | A restore was refused this cycle |

## Verification
The assertions check the window pointer's behaviour on every cycle:
- the decrement and increment with wrap-around;
- holding on an idle cycle, a cancelled move or a refused move;
- the two flags never being high together.

They also check, on every cycle, that register 0 reads zero and that a same-cycle write is forwarded. Whether the address translation is correct can only be shown by the bench's scenarios. These cover globals staying shared across windows, locals staying private, the outgoing/incoming overlap between neighbouring windows, and a write landing in the pre-move window. The bench fills every window, then reads all 32 registers from every window against an independent storage model.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  localparam int LOGICAL_REGS = 32;
  localparam int GLOBAL_REGS  = 8;
  localparam int GROUP_REGS   = 8;
  localparam int WIN_FRESH    = 2 * GROUP_REGS;   // locals + ins per window
  localparam int LA_W         = 5;

  // Total physical entries for a given window count
  function automatic int phys_count(int nwin);
    return GLOBAL_REGS + WIN_FRESH * nwin;
  endfunction

  // Window pointer moved by a save
  function automatic int wrap_dec(int w, int nwin);
    return (w == 0) ? nwin - 1 : w - 1;
  endfunction

  // Window pointer moved by a restore
  function automatic int wrap_inc(int w, int nwin);
    return (w == nwin - 1) ? 0 : w + 1;
  endfunction

  // Logical register number and window -> physical entry
  // Window w owns [base(w) .. base(w)+7] as locals and
  // [base(w)+8 .. base(w)+15] as ins; its outs are the ins of w-1.
  function automatic int phys_of(int lreg, int w, int nwin);
    int base_here;
    int base_prev;
    int idx;
    base_here = GLOBAL_REGS + WIN_FRESH * w;
    base_prev = GLOBAL_REGS + WIN_FRESH * wrap_dec(w, nwin);
    if (lreg < GLOBAL_REGS)
      idx = lreg;
    else if (lreg < GLOBAL_REGS + GROUP_REGS)
      idx = base_prev + GROUP_REGS + (lreg - GLOBAL_REGS);
    else if (lreg < GLOBAL_REGS + 2 * GROUP_REGS)
      idx = base_here + (lreg - GLOBAL_REGS - GROUP_REGS);
    else
      idx = base_here + GROUP_REGS + (lreg - GLOBAL_REGS - 2 * GROUP_REGS);
    return idx;
  endfunction

endpackage

// File: rtl/rwf_addr_map.sv
module rwf_addr_map
  import rwf_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int CW   = 3,
  parameter int PW   = 7
) (
  input  logic [LA_W-1:0] laddr,
  input  logic [CW-1:0]   cwp,
  output logic [PW-1:0]   pidx,
  output logic            is_zero
);

  int idx_full;

  always_comb begin
    idx_full = phys_of(int'(laddr), int'(cwp), NWIN);
  end

  assign pidx    = PW'(idx_full);
  assign is_zero = (laddr == '0);

endmodule

// File: rtl/rwf_win_ctrl.sv
module rwf_win_ctrl
  import rwf_pkg::*;
#(
  parameter int NWIN      = 6,
  parameter int CW        = 3,
  parameter int RESET_CWP = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [CW-1:0]   cwp,
  output logic            overflow,
  output logic            underflow,
  output logic            save_go,
  output logic            restore_go
);

  logic [CW-1:0] cwp_q;
  logic [CW-1:0] cwp_dn;
  logic [CW-1:0] cwp_up;
  logic          lone_save;
  logic          lone_restore;
  logic          dn_blocked;
  logic          up_blocked;

  assign cwp_dn = CW'(wrap_dec(int'(cwp_q), NWIN));
  assign cwp_up = CW'(wrap_inc(int'(cwp_q), NWIN));

  // Save and restore together cancel each other
  assign lone_save    = save_req & ~restore_req;
  assign lone_restore = restore_req & ~save_req;

  assign dn_blocked = win_invalid[cwp_dn];
  assign up_blocked = win_invalid[cwp_up];

  assign overflow   = lone_save & dn_blocked;
  assign underflow  = lone_restore & up_blocked;
  assign save_go    = lone_save & ~dn_blocked;
  assign restore_go = lone_restore & ~up_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cwp_q <= CW'(RESET_CWP);
    else if (save_go)
      cwp_q <= cwp_dn;
    else if (restore_go)
      cwp_q <= cwp_up;
  end

  assign cwp = cwp_q;

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage #(
  parameter int DW   = 32,
  parameter int PHYS = 104,
  parameter int PW   = 7,
  parameter int NRD  = 2
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_idx,
  input  logic                     wr_zero,
  input  logic [DW-1:0]            wr_data,
  input  logic [NRD-1:0][PW-1:0]   rd_idx,
  input  logic [NRD-1:0]           rd_zero,
  output logic [NRD-1:0][DW-1:0]   rd_data
);

  logic [DW-1:0] mem [PHYS];
  logic          wr_live;

  // Writes to register 0 are dropped entirely
  assign wr_live = wr_en & ~wr_zero;

  always_ff @(posedge clk) begin
    if (wr_live)
      mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic fwd_hit;
    assign fwd_hit = wr_live & (wr_idx == rd_idx[p]);
    always_comb begin
      if (rd_zero[p])
        rd_data[p] = '0;
      else if (fwd_hit)
        rd_data[p] = wr_data;
      else
        rd_data[p] = mem[rd_idx[p]];
    end
  end

endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import rwf_pkg::*;
#(
  parameter  int DW        = 32,
  parameter  int NWIN      = 6,
  parameter  int RESET_CWP = 0,
  localparam int CW        = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd0_addr,
  output logic [DW-1:0]   rd0_data,
  input  logic [4:0]      rd1_addr,
  output logic [DW-1:0]   rd1_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [CW-1:0]   cwp_o,
  output logic            overflow_o,
  output logic            underflow_o
);

  localparam int PHYS = phys_count(NWIN);
  localparam int PW   = $clog2(PHYS);
  localparam int NRD  = 2;

  // Named internal events, observed by the checker
  logic ev_save_go;
  logic ev_restore_go;

  logic [CW-1:0]              cwp_cur;
  logic [NRD-1:0][LA_W-1:0]   rd_laddr;
  logic [NRD-1:0][PW-1:0]     rd_pidx;
  logic [NRD-1:0]             rd_zero;
  logic [NRD-1:0][DW-1:0]     rd_word;
  logic [PW-1:0]              wr_pidx;
  logic                       wr_zero;

  rwf_win_ctrl #(
    .NWIN      (NWIN),
    .CW        (CW),
    .RESET_CWP (RESET_CWP)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .win_invalid (win_invalid),
    .cwp         (cwp_cur),
    .overflow    (overflow_o),
    .underflow   (underflow_o),
    .save_go     (ev_save_go),
    .restore_go  (ev_restore_go)
  );

  assign rd_laddr[0] = rd0_addr;
  assign rd_laddr[1] = rd1_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    rwf_addr_map #(
      .NWIN (NWIN),
      .CW   (CW),
      .PW   (PW)
    ) u_map (
      .laddr   (rd_laddr[p]),
      .cwp     (cwp_cur),
      .pidx    (rd_pidx[p]),
      .is_zero (rd_zero[p])
    );
  end

  // Write side uses the pointer before any move in this cycle
  rwf_addr_map #(
    .NWIN (NWIN),
    .CW   (CW),
    .PW   (PW)
  ) u_wmap (
    .laddr   (wr_addr),
    .cwp     (cwp_cur),
    .pidx    (wr_pidx),
    .is_zero (wr_zero)
  );

  rwf_storage #(
    .DW   (DW),
    .PHYS (PHYS),
    .PW   (PW),
    .NRD  (NRD)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_pidx),
    .wr_zero (wr_zero),
    .wr_data (wr_data),
    .rd_idx  (rd_pidx),
    .rd_zero (rd_zero),
    .rd_data (rd_word)
  );

  assign rd0_data = rd_word[0];
  assign rd1_data = rd_word[1];
  assign cwp_o    = cwp_cur;

endmodule

// File: rtl/rwf_checker.sv
module rwf_checker
  import rwf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NWIN = 6,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd0_addr,
  input logic [DW-1:0]   rd0_data,
  input logic [4:0]      rd1_addr,
  input logic [DW-1:0]   rd1_data,
  input logic            wr_en,
  input logic [4:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            save_req,
  input logic            restore_req,
  input logic [CW-1:0]   cwp_o,
  input logic            overflow_o,
  input logic            underflow_o,
  input logic            ev_save_go,
  input logic            ev_restore_go
);

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save_go |=> int'(cwp_o) == wrap_dec(int'($past(cwp_o)), NWIN)); // R6

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore_go |=> int'(cwp_o) == wrap_inc(int'($past(cwp_o)), NWIN)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req) |=> $stable(cwp_o)); // R6

  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> $stable(cwp_o)); // R7

  AST_UNF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> $stable(cwp_o)); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o)); // R7

  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |-> (!overflow_o && !underflow_o)); // R8

  AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> $stable(cwp_o)); // R8

  AST_ZERO_RD0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == 5'd0) |-> (rd0_data == '0)); // R2

  AST_ZERO_RD1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == 5'd0) |-> (rd1_data == '0)); // R2

  AST_FWD_RD0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && wr_addr == rd0_addr) |-> (rd0_data == wr_data)); // R10

  AST_FWD_RD1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && wr_addr == rd1_addr) |-> (rd1_data == wr_data)); // R10

endmodule

bind windowed_regfile rwf_checker #(
  .DW   (DW),
  .NWIN (NWIN),
  .CW   (CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd0_addr      (rd0_addr),
  .rd0_data      (rd0_data),
  .rd1_addr      (rd1_addr),
  .rd1_data      (rd1_data),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .save_req      (save_req),
  .restore_req   (restore_req),
  .cwp_o         (cwp_o),
  .overflow_o    (overflow_o),
  .underflow_o   (underflow_o),
  .ev_save_go    (ev_save_go),
  .ev_restore_go (ev_restore_go)
);

// File: tb/windowed_regfile_tb.sv
`timescale 1ns/1ps
module windowed_regfile_tb;

  localparam int DW   = 32;
  localparam int NWIN = 6;
  localparam int CW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      rd0_addr = '0;
  logic [DW-1:0]   rd0_data;
  logic [4:0]      rd1_addr = '0;
  logic [DW-1:0]   rd1_data;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            save_req = 1'b0;
  logic            restore_req = 1'b0;
  logic [NWIN-1:0] win_invalid = '0;
  logic [CW-1:0]   cwp_o;
  logic            overflow_o;
  logic            underflow_o;

  always #2.5 clk = ~clk;

  windowed_regfile #(.DW(DW), .NWIN(NWIN), .RESET_CWP(0)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd0_addr    (rd0_addr),
    .rd0_data    (rd0_data),
    .rd1_addr    (rd1_addr),
    .rd1_data    (rd1_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .win_invalid (win_invalid),
    .cwp_o       (cwp_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  // Storage model: globals, per-window locals, and per-window link groups.
  // Link group j is the ins of window j and also the outs of window j+1.
  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_loc  [NWIN][8];
  logic [DW-1:0] m_link [NWIN][8];
  int            ecwp = 0;

  function automatic logic [DW-1:0] mget(int r, int w);
    if (r == 0)       return '0;
    else if (r < 8)   return m_glob[r];
    else if (r < 16)  return m_link[(w + NWIN - 1) % NWIN][r - 8];
    else if (r < 24)  return m_loc[w][r - 16];
    else              return m_link[w][r - 24];
  endfunction

  task automatic mset(int r, int w, logic [DW-1:0] v);
    if (r == 0)       ;
    else if (r < 8)   m_glob[r] = v;
    else if (r < 16)  m_link[(w + NWIN - 1) % NWIN][r - 8] = v;
    else if (r < 24)  m_loc[w][r - 16] = v;
    else              m_link[w][r - 24] = v;
  endtask

  function automatic string tag_of(int r);
    if (r == 0)                return "R2";
    else if (r < 8)            return "R3";
    else if (r >= 16 && r < 24) return "R4";
    else                       return "R5";
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input int wa, input logic [DW-1:0] wd,
                       input logic sv, input logic rs, input int a0, input int a1);
    wr_en       = we;
    wr_addr     = 5'(wa);
    wr_data     = wd;
    save_req    = sv;
    restore_req = rs;
    rd0_addr    = 5'(a0);
    rd1_addr    = 5'(a1);
  endtask

  // One clock: model follows the held inputs, then strobes are cleared
  task automatic tick();
    @(posedge clk);
    if (wr_en && wr_addr != 5'd0) mset(int'(wr_addr), ecwp, wr_data);
    if (save_req && !restore_req) begin
      if (!win_invalid[(ecwp + NWIN - 1) % NWIN]) ecwp = (ecwp + NWIN - 1) % NWIN;
    end else if (restore_req && !save_req) begin
      if (!win_invalid[(ecwp + 1) % NWIN]) ecwp = (ecwp + 1) % NWIN;
    end
    @(negedge clk);
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 cwp", DW'(cwp_o), DW'(0));
    chk("R1 ovf", DW'(overflow_o), 0);
    chk("R1 unf", DW'(underflow_o), 0);
    @(negedge clk);

    // Fill every window with unique words, walking upward by restores (R6)
    for (int w = 0; w < NWIN; w++) begin
      for (int r = 1; r < 32; r++) begin
        drive(1'b1, r, 32'hC0DE0000 | DW'(w << 8) | DW'(r), 1'b0, 1'b0, 0, 0);
        tick();
      end
      drive(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
      #1 chk("R6 no flag", DW'(underflow_o), 0);
      tick();
      chk("R6 restore step", DW'(cwp_o), DW'((w + 1) % NWIN));
    end

    // Read every register of every window on both ports (R2 R3 R4 R5 R11)
    for (int w = 0; w < NWIN; w++) begin
      for (int r = 0; r < 32; r++) begin
        drive(1'b0, 0, '0, 1'b0, 1'b0, r, 31 - r);
        #1;
        chk(tag_of(r), rd0_data, mget(r, ecwp));
        chk({tag_of(31 - r), " R11"}, rd1_data, mget(31 - r, ecwp));
      end
      @(negedge clk);
      drive(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
      tick();
    end
    chk("R6 full circle", DW'(cwp_o), DW'(0));

    // R2: writing r0 has no effect and is not forwarded
    drive(1'b1, 0, 32'hFFFFFFFF, 1'b0, 1'b0, 0, 0);
    #1 chk("R2 no fwd", rd0_data, '0);
    tick();
    #1 chk("R2 after write", rd0_data, '0);
    @(negedge clk);

    // R10 forwarding on one port, R11 other port unaffected
    drive(1'b1, 17, 32'h12345678, 1'b0, 1'b0, 17, 16);
    #1;
    chk("R10 fwd", rd0_data, 32'h12345678);
    chk("R11 other port", rd1_data, mget(16, ecwp));
    tick();
    drive(1'b0, 0, '0, 1'b0, 1'b0, 17, 0);
    #1 chk("R10 stored", rd0_data, 32'h12345678);
    @(negedge clk);

    // R6: save from window 0 wraps to NWIN-1 and back
    drive(1'b0, 0, '0, 1'b1, 1'b0, 0, 0);
    #1 chk("R7 no ovf", DW'(overflow_o), 0);
    tick();
    chk("R6 save wrap", DW'(cwp_o), DW'(NWIN - 1));
    drive(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
    tick();
    chk("R6 restore wrap", DW'(cwp_o), DW'(0));

    // R7: overflow when the window below is invalid
    win_invalid = NWIN'(1) << (NWIN - 1);
    drive(1'b0, 0, '0, 1'b1, 1'b0, 0, 0);
    #1;
    chk("R7 ovf", DW'(overflow_o), 1);
    chk("R7 unf quiet", DW'(underflow_o), 0);
    tick();
    chk("R7 ovf hold", DW'(cwp_o), DW'(0));
    // R7: underflow when the window above is invalid
    win_invalid = NWIN'(1) << 1;
    drive(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
    #1;
    chk("R7 unf", DW'(underflow_o), 1);
    chk("R7 ovf quiet", DW'(overflow_o), 0);
    tick();
    chk("R7 unf hold", DW'(cwp_o), DW'(0));
    // R7: an invalid window that is not the target does not block
    win_invalid = NWIN'(1) << 3;
    drive(1'b0, 0, '0, 1'b1, 1'b0, 0, 0);
    #1 chk("R7 far invalid", DW'(overflow_o), 0);
    tick();
    chk("R7 far move", DW'(cwp_o), DW'(NWIN - 1));
    drive(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
    tick();
    win_invalid = '0;

    // R8: simultaneous save and restore cancel
    drive(1'b0, 0, '0, 1'b1, 1'b1, 0, 0);
    #1;
    chk("R8 ovf", DW'(overflow_o), 0);
    chk("R8 unf", DW'(underflow_o), 0);
    tick();
    chk("R8 hold", DW'(cwp_o), DW'(0));

    // R9: write r8 with save in window 0 lands in the caller's outs,
    // seen as r24 of window NWIN-1
    drive(1'b1, 8, 32'hA5A50008, 1'b1, 1'b0, 0, 0);
    tick();
    drive(1'b0, 0, '0, 1'b0, 1'b0, 24, 8);
    #1;
    chk("R9 save write", rd0_data, 32'hA5A50008);
    chk("R9 model", rd0_data, mget(24, ecwp));
    @(negedge clk);

    // R5: outs of window NWIN-1 become ins of window NWIN-2
    drive(1'b1, 12, 32'h0B0B000C, 1'b0, 1'b0, 0, 0);
    tick();
    drive(1'b0, 0, '0, 1'b1, 1'b0, 0, 0);
    tick();
    drive(1'b0, 0, '0, 1'b0, 1'b0, 28, 0);
    #1 chk("R5 overlap", rd0_data, 32'h0B0B000C);
    @(negedge clk);

    // R9: write r27 with restore lands in ins of the pre-move window,
    // seen as r11 after moving up
    drive(1'b1, 27, 32'h5EED001B, 1'b0, 1'b1, 0, 0);
    tick();
    drive(1'b0, 0, '0, 1'b0, 1'b0, 11, 27);
    #1;
    chk("R9 restore write", rd0_data, 32'h5EED001B);
    chk("R9 model", rd1_data, mget(27, ecwp));
    chk("R6 pointer", DW'(cwp_o), DW'(NWIN - 1));
    @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule